// File: doc/BRIEF.md
# Format-Tagged Floating-Point Register File

This block holds the floating-point general registers of a processor core: a parameterised number of 64-bit entries, each with a tag that records how the value was last typed. The tag can be uninterpreted, single, double, word, long, paired-single or unknown. A register that is used in conflicting formats is poisoned. From then on, every typed read of it returns a fixed quiet NaN for the format requested, so software that mixes views of a register sees a recognisable value rather than reinterpreted bits.

One combinational read port and one clocked write port share the array. A mode input picks between two views. With wide registers, each entry holds a whole 64-bit value. With narrow registers, each entry holds 32 bits, and a 64-bit value is spread over an even/odd pair. Accesses that the current view cannot express raise a reserved-instruction flag. Format codes outside the defined set raise a fault flag and poison the register.

Format code encoding, used on both `rd_fmt` and `wr_fmt`:

| Code | Format |
|------|--------|
| 0 | single |
| 1 | double |
| 2 | word |
| 3 | long |
| 4 | paired-single |
| 5 | uninterpreted-32 |
| 6 | uninterpreted-64 |
| 7 | uninterpreted |
| 8 to 15 | unrecognised |

The 32-bit formats are codes 0, 2 and 5. The typed formats are codes 0 to 4.

Top module: `fp_tagged_regfile`

## Requirements
- R1: After reset every register reads as zero and carries the uninterpreted tag. A read with code 6 of any register in wide mode therefore returns 0, with `rd_ri` and `rd_fault` both low.
- R2: A typed read (codes 0 to 4) of an uninterpreted register gives it the requested format as its tag. Later reads in that same format return the stored data.
- R3: A typed read whose format differs from a typed tag sets the tag to unknown. That read, and every later typed read, returns a quiet NaN for the requested format, zero-extended to 64 bits: single 0x7FBFFFFF, word 0x7FFFFFFF, double 0x7FF7FFFFFFFFFFFF, long 0x7FFFFFFFFFFFFFFF, and paired-single 0x7FBFFFFF in both 32-bit halves.
- R4: In narrow mode (`wide_mode`=0), a 64-bit format access (codes 1, 3, 6 and 7) to an even index works as follows. The indexed register holds bits 31:0 and the next register up holds bits 63:32. A write of this kind gives both registers the written tag.
- R5: In narrow mode, any paired-single access and any 64-bit access to an odd index raises the reserved-instruction flag of its port. The read data is then 0, or the quiet NaN when the register is or becomes unknown. Such a write changes no data. It retags the indexed register as unknown, and for an odd 64-bit write it also retags the other register of the pair.
- R6: In wide mode, a 32-bit format write stores 0xDEADC0DE in bits 63:32 and the written data in bits 31:0. A 32-bit format read, in either mode, returns bits 31:0 of the register, zero-extended.
- R7: A write with code 5, 6 or 7 tags the register uninterpreted, so a later typed read adopts a format. Reads with these codes never change a tag, and they return the raw data even when the tag is unknown.
- R8: A read or write with an unrecognised code (8 to 15) raises the fault flag of that port and sets the register's tag to unknown. An unrecognised read returns 0.
- R9: When a read and a write address the same register in the same cycle, the read returns the value from before the write. The write's tag takes precedence over any tag change the read makes.
- R10: In wide mode, a write with code 1, 3, 4 or 6 stores all 64 bits, and a matching read returns them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | 1: 64-bit registers, 0: 32-bit registers with even/odd pairing |
| rd_en | input | 1 | Read strobe; allows the read's tag change and its flags |
| rd_idx | input | 5 | Read register index |
| rd_fmt | input | 4 | Read format code |
| rd_data | output | 64 | Read data (combinational) |
| rd_ri | output | 1 | Reserved-instruction flag for the read |
| rd_fault | output | 1 | Unrecognised-format flag for the read |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write register index |
| wr_fmt | input | 4 | Write format code |
| wr_data | input | 64 | Write data |
| wr_ri | output | 1 | Reserved-instruction flag for the write |
| wr_fault | output | 1 | Unrecognised-format flag for the write |

## Verification
A corrupted tag is invisible until the register is next read with a typed format. At that point, a tag that should have stayed valid yields a quiet NaN in place of the data. A tag that should have been poisoned yields the raw bits. Both show on `rd_data` in the same cycle as the read. A wrong pair layout or fill pattern shows only when the split halves are read back separately with 32-bit codes. For that reason, the directed scenarios always follow a write with reads in several formats and at both indices of a pair.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    localparam int DW = 64;
    localparam int HW = DW / 2;
    localparam int FMT_W = 4;

    localparam logic [FMT_W-1:0] F_SGL = 4'd0;
    localparam logic [FMT_W-1:0] F_DBL = 4'd1;
    localparam logic [FMT_W-1:0] F_WRD = 4'd2;
    localparam logic [FMT_W-1:0] F_LNG = 4'd3;
    localparam logic [FMT_W-1:0] F_PS  = 4'd4;
    localparam logic [FMT_W-1:0] F_U32 = 4'd5;
    localparam logic [FMT_W-1:0] F_U64 = 4'd6;
    localparam logic [FMT_W-1:0] F_UNI = 4'd7;

    localparam logic [HW-1:0] FILL_HI = 32'hDEADC0DE;

    typedef enum logic [2:0] {
        T_UNI = 3'd0,
        T_SGL = 3'd1,
        T_DBL = 3'd2,
        T_WRD = 3'd3,
        T_LNG = 3'd4,
        T_PS  = 3'd5,
        T_UNK = 3'd6
    } tag_e;

    function automatic logic fmt_known(input logic [FMT_W-1:0] f);
        return f <= F_UNI;
    endfunction

    function automatic logic fmt_typed(input logic [FMT_W-1:0] f);
        return f <= F_PS;
    endfunction

    function automatic logic fmt_is32(input logic [FMT_W-1:0] f);
        return (f == F_SGL) || (f == F_WRD) || (f == F_U32);
    endfunction

    function automatic tag_e fmt_tag(input logic [FMT_W-1:0] f);
        case (f)
            F_SGL:   return T_SGL;
            F_DBL:   return T_DBL;
            F_WRD:   return T_WRD;
            F_LNG:   return T_LNG;
            F_PS:    return T_PS;
            default: return T_UNI;
        endcase
    endfunction

    function automatic logic [DW-1:0] fmt_qnan(input logic [FMT_W-1:0] f);
        case (f)
            F_SGL:   return {{HW{1'b0}}, 32'h7FBFFFFF};
            F_WRD:   return {{HW{1'b0}}, 32'h7FFFFFFF};
            F_DBL:   return 64'h7FF7_FFFF_FFFF_FFFF;
            F_LNG:   return 64'h7FFF_FFFF_FFFF_FFFF;
            F_PS:    return {2{32'h7FBFFFFF}};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/fprf_rd_path.sv
module fprf_rd_path
    import fprf_pkg::*;
(
    input  logic             en,
    input  logic             wide,
    input  logic [FMT_W-1:0] fmt,
    input  logic             idx_odd,
    input  tag_e             tag_cur,
    input  logic [DW-1:0]    lo_reg,
    input  logic [HW-1:0]    hi_half,
    output logic [DW-1:0]    data,
    output logic             ri,
    output logic             fault,
    output logic             tag_we,
    output tag_e             tag_new
);
    tag_e eff_tag;
    logic illegal;

    always_comb begin
        data    = '0;
        ri      = 1'b0;
        fault   = 1'b0;
        tag_we  = 1'b0;
        tag_new = tag_cur;
        eff_tag = tag_cur;
        illegal = 1'b0;
        if (!fmt_known(fmt)) begin
            fault   = en;
            tag_we  = en;
            tag_new = T_UNK;
        end else begin
            if (fmt_typed(fmt)) begin
                if (tag_cur == T_UNI) begin
                    tag_we  = en;
                    tag_new = fmt_tag(fmt);
                    eff_tag = fmt_tag(fmt);
                end else if (tag_cur != fmt_tag(fmt)) begin
                    tag_we  = en;
                    tag_new = T_UNK;
                    eff_tag = T_UNK;
                end
            end
            illegal = !wide && ((fmt == F_PS) || (!fmt_is32(fmt) && idx_odd));
            ri      = en && illegal;
            if (fmt_typed(fmt) && eff_tag == T_UNK)
                data = fmt_qnan(fmt);
            else if (illegal)
                data = '0;
            else if (fmt_is32(fmt))
                data = {{HW{1'b0}}, lo_reg[HW-1:0]};
            else if (wide)
                data = lo_reg;
            else
                data = {hi_half, lo_reg[HW-1:0]};
        end
    end

endmodule

// File: rtl/fprf_wr_path.sv
module fprf_wr_path
    import fprf_pkg::*;
(
    input  logic             en,
    input  logic             wide,
    input  logic [FMT_W-1:0] fmt,
    input  logic             idx_odd,
    input  logic [DW-1:0]    wdata,
    output logic             p_dwe,
    output logic [DW-1:0]    p_data,
    output logic             p_twe,
    output tag_e             p_tag,
    output logic             q_dwe,
    output logic [DW-1:0]    q_data,
    output logic             q_twe,
    output tag_e             q_tag,
    output logic             ri,
    output logic             fault
);
    always_comb begin
        p_dwe  = 1'b0;
        p_data = '0;
        p_twe  = 1'b0;
        p_tag  = T_UNK;
        q_dwe  = 1'b0;
        q_data = '0;
        q_twe  = 1'b0;
        q_tag  = T_UNK;
        ri     = 1'b0;
        fault  = 1'b0;
        if (!fmt_known(fmt)) begin
            p_twe = en;
            fault = en;
        end else if (fmt_is32(fmt)) begin
            p_dwe  = en;
            p_twe  = en;
            p_tag  = fmt_tag(fmt);
            p_data = {wide ? FILL_HI : {HW{1'b0}}, wdata[HW-1:0]};
        end else if (wide) begin
            p_dwe  = en;
            p_twe  = en;
            p_tag  = fmt_tag(fmt);
            p_data = wdata;
        end else if (fmt == F_PS) begin
            p_twe = en;
            ri    = en;
        end else if (idx_odd) begin
            p_twe = en;
            q_twe = en;
            ri    = en;
        end else begin
            p_dwe  = en;
            p_twe  = en;
            p_tag  = fmt_tag(fmt);
            p_data = {{HW{1'b0}}, wdata[HW-1:0]};
            q_dwe  = en;
            q_twe  = en;
            q_tag  = fmt_tag(fmt);
            q_data = {{HW{1'b0}}, wdata[DW-1:HW]};
        end
    end

endmodule

// File: rtl/fp_tagged_regfile.sv
module fp_tagged_regfile
    import fprf_pkg::*;
#(
    parameter int NREG = 32,
    localparam int IW = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide_mode,
    input  logic             rd_en,
    input  logic [IW-1:0]    rd_idx,
    input  logic [FMT_W-1:0] rd_fmt,
    output logic [DW-1:0]    rd_data,
    output logic             rd_ri,
    output logic             rd_fault,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [FMT_W-1:0] wr_fmt,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_ri,
    output logic             wr_fault
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] data;
        tag_e [NREG-1:0]         tag;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [IW-1:0] rd_pair_idx, wr_pair_idx;
    logic          rd_tag_we;
    tag_e          rd_tag_new;
    logic          p_dwe, p_twe, q_dwe, q_twe;
    logic [DW-1:0] p_data, q_data;
    tag_e          p_tag, q_tag;

    assign rd_pair_idx = rd_idx | IW'(1);
    assign wr_pair_idx = wr_idx ^ IW'(1);

    fprf_rd_path u_rd (
        .en      (rd_en),
        .wide    (wide_mode),
        .fmt     (rd_fmt),
        .idx_odd (rd_idx[0]),
        .tag_cur (st_q.tag[rd_idx]),
        .lo_reg  (st_q.data[rd_idx]),
        .hi_half (st_q.data[rd_pair_idx][HW-1:0]),
        .data    (rd_data),
        .ri      (rd_ri),
        .fault   (rd_fault),
        .tag_we  (rd_tag_we),
        .tag_new (rd_tag_new)
    );

    fprf_wr_path u_wr (
        .en      (wr_en),
        .wide    (wide_mode),
        .fmt     (wr_fmt),
        .idx_odd (wr_idx[0]),
        .wdata   (wr_data),
        .p_dwe   (p_dwe),
        .p_data  (p_data),
        .p_twe   (p_twe),
        .p_tag   (p_tag),
        .q_dwe   (q_dwe),
        .q_data  (q_data),
        .q_twe   (q_twe),
        .q_tag   (q_tag),
        .ri      (wr_ri),
        .fault   (wr_fault)
    );

    // Read-side tag change first; write side overrides it on a collision.
    always_comb begin
        st_d = st_q;
        if (rd_tag_we) st_d.tag[rd_idx] = rd_tag_new;
        if (p_dwe)     st_d.data[wr_idx] = p_data;
        if (p_twe)     st_d.tag[wr_idx] = p_tag;
        if (q_dwe)     st_d.data[wr_pair_idx] = q_data;
        if (q_twe)     st_d.tag[wr_pair_idx] = q_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data <= '0;
            for (int i = 0; i < NREG; i++) st_q.tag[i] <= T_UNI;
        end else begin
            st_q <= st_d;
        end
    end

    p_qnan_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fmt == F_SGL && st_q.tag[rd_idx] == T_UNK) |-> rd_data == 64'h7FBFFFFF);

    p_pair_tags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wide_mode && !wr_idx[0] && (wr_fmt == F_DBL || wr_fmt == F_LNG))
        |=> st_q.tag[$past(wr_pair_idx)] == st_q.tag[$past(wr_idx)]);

    p_ri_keeps_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ri) |=> st_q.data[$past(wr_idx)] == $past(st_q.data[wr_idx]));

    p_fill_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wide_mode && (wr_fmt == F_SGL || wr_fmt == F_WRD))
        |=> st_q.data[$past(wr_idx)][DW-1:HW] == FILL_HI);

    p_fault_poisons_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fault) |=> st_q.tag[$past(wr_idx)] == T_UNK);

    p_flags_need_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> !rd_ri && !rd_fault);

endmodule

// File: tb/fp_tagged_regfile_tb.sv
module fp_tagged_regfile_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b1;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [3:0]  rd_fmt = '0;
    logic [63:0] rd_data;
    logic        rd_ri, rd_fault;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [3:0]  wr_fmt = '0;
    logic [63:0] wr_data = '0;
    logic        wr_ri, wr_fault;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_tagged_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_fmt(rd_fmt),
        .rd_data(rd_data), .rd_ri(rd_ri), .rd_fault(rd_fault),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_fmt(wr_fmt),
        .wr_data(wr_data), .wr_ri(wr_ri), .wr_fault(wr_fault)
    );

    localparam logic [3:0] SGL = 0, DBL = 1, WRD = 2, LNG = 3, PS = 4,
                           U32 = 5, U64 = 6, UNI = 7;
    localparam logic [63:0] QS = 64'h7FBFFFFF, QW = 64'h7FFFFFFF,
                            QD = 64'h7FF7FFFFFFFFFFFF, QL = 64'h7FFFFFFFFFFFFFFF,
                            QP = 64'h7FBFFFFF7FBFFFFF;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] i, input logic [3:0] f, input logic [63:0] exp,
                      input logic exp_ri, input logic exp_flt, input string req);
        @(negedge clk);
        rd_en = 1; rd_idx = i; rd_fmt = f;
        #1;
        check(req, "rd_data", rd_data, exp);
        check(req, "rd_ri", 64'(rd_ri), 64'(exp_ri));
        check(req, "rd_fault", 64'(rd_fault), 64'(exp_flt));
        @(posedge clk); #1 rd_en = 0;
    endtask

    task automatic wr(input logic [4:0] i, input logic [3:0] f, input logic [63:0] d,
                      input logic exp_ri, input logic exp_flt, input string req);
        @(negedge clk);
        wr_en = 1; wr_idx = i; wr_fmt = f; wr_data = d;
        #1;
        check(req, "wr_ri", 64'(wr_ri), 64'(exp_ri));
        check(req, "wr_fault", 64'(wr_fault), 64'(exp_flt));
        @(posedge clk); #1 wr_en = 0;
    endtask

    task automatic t_reset_and_adopt;
        wide_mode = 1;
        rd(5'd5, U64, 64'h0, 0, 0, "R1");
        rd(5'd3, SGL, 64'h0, 0, 0, "R2");
        rd(5'd3, SGL, 64'h0, 0, 0, "R2");
        rd(5'd3, DBL, QD, 0, 0, "R3");
        rd(5'd3, SGL, QS, 0, 0, "R3");
    endtask

    task automatic t_wide_typed;
        wr(5'd4, DBL, 64'h4009_21FB_5444_2D18, 0, 0, "R10");
        rd(5'd4, DBL, 64'h4009_21FB_5444_2D18, 0, 0, "R10");
        rd(5'd4, LNG, QL, 0, 0, "R3");
        rd(5'd4, WRD, QW, 0, 0, "R3");
        rd(5'd4, PS,  QP, 0, 0, "R3");
        rd(5'd4, U64, 64'h4009_21FB_5444_2D18, 0, 0, "R7");
        wr(5'd9, PS, 64'h3F80_0000_4000_0000, 0, 0, "R10");
        rd(5'd9, PS, 64'h3F80_0000_4000_0000, 0, 0, "R10");
    endtask

    task automatic t_fill;
        wr(5'd6, SGL, 64'h1122_3344_5566_7788, 0, 0, "R6");
        rd(5'd6, U64, 64'hDEAD_C0DE_5566_7788, 0, 0, "R6");
        rd(5'd6, SGL, 64'h0000_0000_5566_7788, 0, 0, "R6");
    endtask

    task automatic t_uninterp;
        wr(5'd7, U32, 64'hAAAA_BBBB_CCCC_DDDD, 0, 0, "R7");
        rd(5'd7, U64, 64'hDEAD_C0DE_CCCC_DDDD, 0, 0, "R7");
        rd(5'd7, WRD, 64'h0000_0000_CCCC_DDDD, 0, 0, "R7");
        rd(5'd7, SGL, QS, 0, 0, "R7");
        wr(5'd8, DBL, 64'h0102_0304_0506_0708, 0, 0, "R7");
        rd(5'd8, U32, 64'h0000_0000_0506_0708, 0, 0, "R7");
        rd(5'd8, DBL, 64'h0102_0304_0506_0708, 0, 0, "R7");
    endtask

    task automatic t_narrow;
        wide_mode = 0;
        wr(5'd10, DBL, 64'h0123_4567_89AB_CDEF, 0, 0, "R4");
        rd(5'd10, U32, 64'h0000_0000_89AB_CDEF, 0, 0, "R4");
        rd(5'd11, U32, 64'h0000_0000_0123_4567, 0, 0, "R4");
        rd(5'd10, DBL, 64'h0123_4567_89AB_CDEF, 0, 0, "R4");
        rd(5'd11, DBL, 64'h0, 1, 0, "R5");
        wr(5'd13, DBL, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R5");
        rd(5'd12, U64, 64'h0, 0, 0, "R5");
        rd(5'd12, SGL, QS, 0, 0, "R5");
        rd(5'd13, WRD, QW, 0, 0, "R5");
        rd(5'd14, PS, 64'h0, 1, 0, "R5");
        wr(5'd14, PS, 64'h1234, 1, 0, "R5");
        rd(5'd14, WRD, QW, 0, 0, "R5");
        wide_mode = 1;
    endtask

    task automatic t_fault;
        wr(5'd20, 4'd9, 64'h55, 0, 1, "R8");
        rd(5'd20, SGL, QS, 0, 0, "R8");
        rd(5'd21, 4'd12, 64'h0, 0, 1, "R8");
        rd(5'd21, LNG, QL, 0, 0, "R8");
    endtask

    task automatic t_collide;
        wr(5'd25, DBL, 64'hAAAA_0000_0000_0001, 0, 0, "R9");
        @(negedge clk);
        wr_en = 1; wr_idx = 5'd25; wr_fmt = DBL; wr_data = 64'hBBBB_0000_0000_0002;
        rd_en = 1; rd_idx = 5'd25; rd_fmt = LNG;
        #1;
        check("R9", "rd_data old", rd_data, QL);
        @(posedge clk); #1 wr_en = 0; rd_en = 0;
        rd(5'd25, DBL, 64'hBBBB_0000_0000_0002, 0, 0, "R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset_and_adopt();
        t_wide_typed();
        t_fill();
        t_uninterp();
        t_narrow();
        t_fault();
        t_collide();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule